// File: doc/BRIEF.md
# Carry-Cycle DMA Request Router

This block sits between a peripheral that has one DMA request line and one DMA acknowledge line, and a DMA controller that has two channels. In normal use it forwards the peripheral's request to channel 0 and returns either channel's acknowledge to the peripheral. All timing inputs are asynchronous. They are synchronized to `clk`, and acknowledge release edges are detected from registered samples.

When the carry-cycle enable input is high, a DONE pulse that arrives while channel 0 is acknowledging starts a chained sequence. First a request goes to channel 1. The first transfer that channel 1 acknowledges is a single carry byte that must land in the peripheral's auxiliary register as an ordinary register write. For the whole of that acknowledge the block:
- suppresses the peripheral DMA acknowledge,
- forces the write strobe active so that the transfer reads memory and writes the peripheral,
- drives the register-select lines to a parameterised auxiliary address,
- asserts chip-select.

After the carry byte, one more normal peripheral request is routed to channel 1. When that transfer ends, all further requests are masked and an all-done flag stays high until reset.

Top module: `cc_dma_router`

## Requirements
- R1: After reset, `ch1_req_n_o`=1, `cs_n_o`=1, `rs_ovr_o`=0 and `all_done_o`=0. `ch0_req_n_o` is the inverse of `dreq_i`.
- R2: While `carry_en_i`=0, a DONE pulse (`done_n_i`=0 together with `ack0_n_i`=0) leaves `ch1_req_n_o` at 1 and the routing unchanged.
- R3: While `carry_en_i`=1, a DONE pulse during a channel 0 acknowledge drives `ch1_req_n_o` to 0. It stays at 0 until channel 1 acknowledges (`ack1_n_i`=0).
- R4: Outside the carry byte, `pack_n_o` is low exactly when `ack0_n_i` or `ack1_n_i` is low. During the carry byte, `pack_n_o` is held high.
- R5: During the carry byte, `wr_n_o`=0 whatever the value of `wr_n_i`. At all other times, `wr_n_o` follows `wr_n_i`.
- R6: During the carry byte, `rs_o`=AUX_ADDR (default 3'd5), `rs_ovr_o`=1 and `cs_n_o`=0. At all other times, `rs_o`=0, `rs_ovr_o`=0 and `cs_n_o`=1.
- R7: A peripheral request that is present during the carry byte reaches no channel 1 request until the carry byte's acknowledge is released. From then on it drives `ch1_req_n_o` low, and `ch0_req_n_o` stays high.
- R8: When the acknowledge of the following normal channel 1 transfer is released, `all_done_o` goes to 1 and both channel requests stay high until reset, whatever `dreq_i` or a later DONE does.
- R9: Between the DONE pulse and the end of the carry byte, `ch0_req_n_o` still follows `dreq_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| carry_en_i | input | 1 | Carry-cycle mode enable (static configuration) |
| dreq_i | input | 1 | Peripheral DMA request, active high |
| done_n_i | input | 1 | Controller DONE pulse, active low |
| ack0_n_i | input | 1 | Channel 0 acknowledge, active low |
| ack1_n_i | input | 1 | Channel 1 acknowledge, active low |
| wr_n_i | input | 1 | Controller write strobe, active low |
| ch0_req_n_o | output | 1 | Channel 0 request, active low |
| ch1_req_n_o | output | 1 | Channel 1 request, active low |
| pack_n_o | output | 1 | Peripheral DMA acknowledge, active low |
| wr_n_o | output | 1 | Write strobe after the direction override, active low |
| rs_o | output | RS_W | Register-select value to drive |
| rs_ovr_o | output | 1 | Register-select override active |
| cs_n_o | output | 1 | Peripheral chip-select, active low |
| all_done_o | output | 1 | Sequence complete, requests masked |

## Verification
With two synchronizer stages, a change on `dreq_i`, an acknowledge or `wr_n_i` reaches the combinational outputs on the second rising edge after it. An effect that goes through a phase change (a DONE that raises the channel 1 request, the start of masking after an acknowledge release) needs one more edge, so it is due on the third. The bench drives inputs on a falling edge, waits four rising edges and samples on the next falling edge. Every result is therefore due by the time it is read, and no result depends on the order of processes at an edge.

// File: rtl/cc_dma_pkg.sv
// Shared types for the carry-cycle DMA router.
// Assumes one clock domain, in which every sequencing decision is made.
package cc_dma_pkg;
    // Sequencing phases of the router
    typedef enum logic [2:0] {
        PH_CH0   = 3'd0,  // requests routed to channel 0
        PH_CREQ  = 3'd1,  // DONE seen, channel 1 request pending
        PH_CARRY = 3'd2,  // carry byte acknowledge in progress
        PH_LAST  = 3'd3,  // state flop set: final transfer on channel 1
        PH_MASK  = 3'd4   // sequence finished, requests masked
    } phase_t;
endpackage

// File: rtl/cc_sync.sv
// Multi-stage synchronizer bank for W asynchronous inputs.
// Assumes every bit changes slowly enough to be sampled on a level basis.
// The reset value is set per bit so that idle strobes come out of reset inactive.
module cc_sync #(
    parameter int unsigned W      = 4,
    parameter int unsigned STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stage_q [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                // First stage: capture the raw inputs
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[g] <= RST_VAL;
                    else        stage_q[g] <= din;
                end
            end else begin : g_next
                // Further stages: settle metastability
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[g] <= RST_VAL;
                    else        stage_q[g] <= stage_q[g-1];
                end
            end
        end
    endgenerate

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/cc_edge.sv
// Detects the release (active-high to inactive) of a synchronized strobe.
// Assumes the input is already synchronous to clk. The output is a
// single-cycle pulse in the cycle where the release is first seen.
module cc_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic fall
);
    logic prev_q;

    // Remember the last sampled level
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= lvl;
    end

    assign fall = prev_q & ~lvl;
endmodule

// File: rtl/cc_seq.sv
// Phase sequencer for the carry-cycle chain.
// Assumes active-high synchronized inputs. ack1_end marks the release of
// the channel 1 acknowledge. The carry enable is only read in PH_CH0.
module cc_seq
    import cc_dma_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   carry_en,
    input  logic   done,
    input  logic   ack0,
    input  logic   ack1,
    input  logic   ack1_end,
    output phase_t phase
);
    phase_t phase_d;

    // Next-phase decision
    always_comb begin
        phase_d = phase;
        unique case (phase)
            PH_CH0:   if (carry_en && done && ack0) phase_d = PH_CREQ;
            PH_CREQ:  if (ack1)                     phase_d = PH_CARRY;
            PH_CARRY: if (ack1_end)                 phase_d = PH_LAST;
            PH_LAST:  if (ack1_end)                 phase_d = PH_MASK;
            PH_MASK:                                phase_d = PH_MASK;
            default:                                phase_d = PH_CH0;
        endcase
    end

    // Phase register
    always_ff @(posedge clk) begin
        if (!rst_n) phase <= PH_CH0;
        else        phase <= phase_d;
    end
endmodule

// File: rtl/cc_route.sv
// Output routing and carry-byte overrides, all active high.
// Assumes synchronized inputs and the current phase. The carry byte is
// active from the first channel 1 acknowledge until its release.
module cc_route
    import cc_dma_pkg::*;
#(
    parameter int unsigned   RS_W     = 3,
    parameter logic [RS_W-1:0] AUX_ADDR = '0
) (
    input  phase_t          phase,
    input  logic            req,
    input  logic            ack0,
    input  logic            ack1,
    input  logic            wr,
    output logic            ch0_req,
    output logic            ch1_req,
    output logic            pack,
    output logic            wr_out,
    output logic [RS_W-1:0] rs,
    output logic            rs_ovr,
    output logic            cs,
    output logic            all_done
);
    logic carry_byte;

    // Carry-byte indication covers the entire first channel 1 acknowledge
    always_comb begin
        carry_byte = (phase == PH_CARRY) || ((phase == PH_CREQ) && ack1);
    end

    // Request steering per phase
    always_comb begin
        ch0_req = 1'b0;
        ch1_req = 1'b0;
        unique case (phase)
            PH_CH0:   ch0_req = req;
            PH_CREQ:  begin ch0_req = req; ch1_req = ~ack1; end
            PH_CARRY: ch0_req = req;
            PH_LAST:  ch1_req = req;
            default:  ;
        endcase
    end

    // Acknowledge and carry-byte overrides
    always_comb begin
        pack     = (ack0 | ack1) & ~carry_byte;
        wr_out   = wr | carry_byte;
        rs       = carry_byte ? AUX_ADDR : '0;
        rs_ovr   = carry_byte;
        cs       = carry_byte;
        all_done = (phase == PH_MASK);
    end
endmodule

// File: rtl/cc_dma_router.sv
// Carry-cycle DMA request router (top).
// Synchronizes the asynchronous strobes, sequences the carry-cycle chain
// and drives active-low strobes at the ports. Assumes carry_en_i is static
// configuration that is already synchronous to clk.
module cc_dma_router
    import cc_dma_pkg::*;
#(
    parameter int unsigned     SYNC_STAGES = 2,
    parameter int unsigned     RS_W        = 3,
    parameter logic [RS_W-1:0] AUX_ADDR    = 3'd5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            carry_en_i,
    input  logic            dreq_i,
    input  logic            done_n_i,
    input  logic            ack0_n_i,
    input  logic            ack1_n_i,
    input  logic            wr_n_i,
    output logic            ch0_req_n_o,
    output logic            ch1_req_n_o,
    output logic            pack_n_o,
    output logic            wr_n_o,
    output logic [RS_W-1:0] rs_o,
    output logic            rs_ovr_o,
    output logic            cs_n_o,
    output logic            all_done_o
);
    localparam int unsigned NSYNC = 5;

    logic [NSYNC-1:0] raw, syn;
    logic   req_s, done_s, ack0_s, ack1_s, wr_s, ack1_end;
    phase_t phase;
    logic   ch0_req, ch1_req, pack, wr_out, cs;

    // Invert the active-low strobes to active high before synchronizing
    assign raw = {~wr_n_i, ~ack1_n_i, ~ack0_n_i, ~done_n_i, dreq_i};
    assign {wr_s, ack1_s, ack0_s, done_s, req_s} = syn;

    cc_sync #(.W(NSYNC), .STAGES(SYNC_STAGES), .RST_VAL('0)) sync_i (
        .clk(clk), .rst_n(rst_n), .din(raw), .dout(syn)
    );

    cc_edge ack1_edge_i (
        .clk(clk), .rst_n(rst_n), .lvl(ack1_s), .fall(ack1_end)
    );

    cc_seq seq_i (
        .clk(clk), .rst_n(rst_n), .carry_en(carry_en_i), .done(done_s),
        .ack0(ack0_s), .ack1(ack1_s), .ack1_end(ack1_end), .phase(phase)
    );

    cc_route #(.RS_W(RS_W), .AUX_ADDR(AUX_ADDR)) route_i (
        .phase(phase), .req(req_s), .ack0(ack0_s), .ack1(ack1_s), .wr(wr_s),
        .ch0_req(ch0_req), .ch1_req(ch1_req), .pack(pack), .wr_out(wr_out),
        .rs(rs_o), .rs_ovr(rs_ovr_o), .cs(cs), .all_done(all_done_o)
    );

    // Port polarity
    assign ch0_req_n_o = ~ch0_req;
    assign ch1_req_n_o = ~ch1_req;
    assign pack_n_o    = ~pack;
    assign wr_n_o      = ~wr_out;
    assign cs_n_o      = ~cs;
endmodule

// File: rtl/cc_dma_router_chk.sv
// Port-level property checker for cc_dma_router, attached by bind.
module cc_dma_router_chk #(
    parameter int unsigned     RS_W     = 3,
    parameter logic [RS_W-1:0] AUX_ADDR = 3'd5
) (
    input logic            clk,
    input logic            rst_n,
    input logic            carry_en_i,
    input logic            dreq_i,
    input logic            done_n_i,
    input logic            ack0_n_i,
    input logic            ack1_n_i,
    input logic            wr_n_i,
    input logic            ch0_req_n_o,
    input logic            ch1_req_n_o,
    input logic            pack_n_o,
    input logic            wr_n_o,
    input logic [RS_W-1:0] rs_o,
    input logic            rs_ovr_o,
    input logic            cs_n_o,
    input logic            all_done_o
);
    // R4: no peripheral acknowledge while chip-select carries the carry byte
    a_r4_no_pack_in_carry: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n_o |-> pack_n_o);

    // R5, R6: carry byte drives the auxiliary address as a forced write
    a_r6_aux_write: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n_o |-> (rs_ovr_o && rs_o == AUX_ADDR && !wr_n_o));

    // R6: outside the carry byte the select lines are released
    a_r6_rs_idle: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_o |-> (!rs_ovr_o && rs_o == '0));

    // R8: once finished, both channel requests stay masked
    a_r8_masked: assert property (@(posedge clk) disable iff (!rst_n)
        all_done_o |-> (ch0_req_n_o && ch1_req_n_o && cs_n_o));

    // R8: the finished flag is sticky until reset
    a_r8_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        all_done_o |=> all_done_o);
endmodule

bind cc_dma_router cc_dma_router_chk #(.RS_W(RS_W), .AUX_ADDR(AUX_ADDR)) chk_i (.*);

// File: tb/cc_dma_router_tb_top.sv
// Self-checking bench for cc_dma_router: a vector table for channel 0
// routing, then directed tests of the carry-cycle chain.
module cc_dma_router_tb_top;
    localparam int unsigned RS_W = 3;
    localparam logic [RS_W-1:0] AUX = 3'd5;
    localparam int NVEC = 5;
    // {dreq, ack0_n, ack1_n, wr_n, exp ch0_req_n, exp ch1_req_n, exp pack_n, exp wr_n}
    localparam logic [NVEC-1:0][7:0] VEC = {
        8'b0110_1110,
        8'b0101_1101,
        8'b1010_0100,
        8'b0011_1101,
        8'b1111_0111
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic carry_en = 1'b0, dreq = 1'b0, done_n = 1'b1;
    logic ack0_n = 1'b1, ack1_n = 1'b1, wr_n = 1'b1;
    logic ch0_req_n, ch1_req_n, pack_n, wr_n_out, rs_ovr, cs_n, all_done;
    logic [RS_W-1:0] rs;
    int checks = 0, errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    cc_dma_router #(.SYNC_STAGES(2), .RS_W(RS_W), .AUX_ADDR(AUX)) dut_i (
        .clk(clk), .rst_n(rst_n), .carry_en_i(carry_en), .dreq_i(dreq),
        .done_n_i(done_n), .ack0_n_i(ack0_n), .ack1_n_i(ack1_n), .wr_n_i(wr_n),
        .ch0_req_n_o(ch0_req_n), .ch1_req_n_o(ch1_req_n), .pack_n_o(pack_n),
        .wr_n_o(wr_n_out), .rs_o(rs), .rs_ovr_o(rs_ovr), .cs_n_o(cs_n),
        .all_done_o(all_done)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Four rising edges cover every latency; sample on the falling edge after
    task automatic settle();
        repeat (4) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        dreq = 1'b0; done_n = 1'b1; ack0_n = 1'b1; ack1_n = 1'b1; wr_n = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        settle();
    endtask

    initial begin
        #(8 * 20000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        do_reset();
        chk("R1 ch0_req_n", ch0_req_n, 1);
        chk("R1 ch1_req_n", ch1_req_n, 1);
        chk("R1 cs_n", cs_n, 1);
        chk("R1 rs_ovr", rs_ovr, 0);
        chk("R1 all_done", all_done, 0);

        // R1, R4, R5: channel 0 routing table
        for (int i = 0; i < NVEC; i++) begin
            dreq = VEC[i][7]; ack0_n = VEC[i][6]; ack1_n = VEC[i][5]; wr_n = VEC[i][4];
            settle();
            chk("R1 table ch0/ch1", {6'b0, ch0_req_n, ch1_req_n}, {6'b0, VEC[i][3:2]});
            chk("R4 table pack_n", pack_n, VEC[i][1]);
            chk("R5 table wr_n", wr_n_out, VEC[i][0]);
        end

        // R2: DONE with carry mode off has no effect
        carry_en = 1'b0; done_n = 1'b0; ack0_n = 1'b0;
        settle();
        done_n = 1'b1; ack0_n = 1'b1;
        settle();
        chk("R2 ch1_req_n", ch1_req_n, 1);
        chk("R2 cs_n", cs_n, 1);
        dreq = 1'b1;
        settle();
        chk("R2 ch0 routing", ch0_req_n, 0);
        dreq = 1'b0;

        // R3: DONE in carry mode raises the channel 1 request
        carry_en = 1'b1; done_n = 1'b0; ack0_n = 1'b0;
        settle();
        done_n = 1'b1; ack0_n = 1'b1;
        settle();
        chk("R3 ch1_req_n", ch1_req_n, 0);
        chk("R3 cs_n before ack", cs_n, 1);
        dreq = 1'b1;
        settle();
        chk("R9 ch0 follows req", ch0_req_n, 0);
        chk("R3 ch1 held", ch1_req_n, 0);

        // Carry byte: channel 1 acknowledge, configured as a read (wr_n high)
        ack1_n = 1'b0; wr_n = 1'b1;
        settle();
        chk("R4 pack_n in carry", pack_n, 1);
        chk("R5 wr forced", wr_n_out, 0);
        chk("R6 rs aux", rs, AUX);
        chk("R6 rs_ovr", rs_ovr, 1);
        chk("R6 cs_n", cs_n, 0);
        chk("R7 req held off", ch1_req_n, 1);
        chk("R9 ch0 still", ch0_req_n, 0);

        // Release of the carry byte acknowledge
        ack1_n = 1'b1;
        settle();
        chk("R7 ch1 req", ch1_req_n, 0);
        chk("R7 ch0 idle", ch0_req_n, 1);
        chk("R6 cs released", cs_n, 1);
        chk("R5 wr released", wr_n_out, 1);
        chk("R8 not done yet", all_done, 0);

        // Final normal transfer on channel 1
        ack1_n = 1'b0; wr_n = 1'b0;
        settle();
        chk("R4 pack_n normal", pack_n, 0);
        chk("R6 no cs", cs_n, 1);
        chk("R6 rs zero", {rs_ovr, rs}, 0);
        chk("R5 wr follows", wr_n_out, 0);
        ack1_n = 1'b1; wr_n = 1'b1;
        settle();
        chk("R8 all_done", all_done, 1);
        chk("R8 ch1 masked", ch1_req_n, 1);
        chk("R8 ch0 masked", ch0_req_n, 1);

        // R8: a later DONE changes nothing
        done_n = 1'b0; ack0_n = 1'b0;
        settle();
        done_n = 1'b1; ack0_n = 1'b1;
        settle();
        chk("R8 still masked", {6'b0, ch0_req_n, ch1_req_n}, 8'd3);
        chk("R8 still done", all_done, 1);

        // R1: a second reset restores channel 0 routing
        carry_en = 1'b0;
        do_reset();
        chk("R1 done cleared", all_done, 0);
        dreq = 1'b1;
        settle();
        chk("R1 ch0 after reset", ch0_req_n, 0);

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule